// File: doc/BRIEF.md
# Immediate-Operand ALU Execution Unit

This unit runs one integer ALU instruction per clock cycle for a small sequential 64-bit processor. It receives a ten-byte instruction window in which byte 0 sits in the least significant bits. The unit decodes the opcode and function nibbles and reads its register file. For the register-register family it combines two registers. For the register-immediate family it combines a register with a 64-bit constant carried in the instruction. In either case it writes the result back, sets the condition codes and advances the program counter by the length of the instruction.

Any encoding outside these two families stops the unit in an illegal-instruction state. The unit then ignores further instructions until reset. A combinational read port lets the surrounding logic look at any register.

Top module: `imm_alu_core`

## Requirements
- R1: While and after reset, the unit shows these values: pc_o is 0, status_o is 0 (running), cc_o is 3'b100, and every register reads 0 on the peek port.
- R2: An immediate instruction is encoded as follows. Byte 0 is {4'hC, fn}. Byte 1 is {rA, 4'hF}. Bytes 2 to 9 hold a constant in little-endian order. The function codes are fn 0 add, 1 subtract, 2 AND, 3 XOR. The unit computes constant OP rA and writes the result to rA.
- R3: For an immediate subtract, the constant is the minuend and rA is the subtrahend. With a constant of 0 the instruction negates rA.
- R4: A register instruction is encoded as follows. Byte 0 is {4'h6, fn}, using the same function codes as R2. Byte 1 is {rA, rB}. The unit computes rB OP rA, writes the result to rB, and advances pc_o by 2.
- R5: An accepted immediate instruction advances pc_o by 10.
- R6: cc_o is {ZF, SF, OF}. ZF is set when the result is zero. SF is bit 63 of the result. OF is signed overflow for add and subtract, and it is 0 for AND and XOR.
- R7: Register ID 15 always reads 0, and writes to it are discarded.
- R8: An instruction is illegal if its opcode is neither 6 nor C, if its fn is above 3, or if it is an immediate instruction whose byte-1 low nibble is not F. An illegal instruction sets status_o to 1 and leaves pc_o, cc_o and all registers unchanged.
- R9: While status_o is 1, every instruction is ignored until reset.
- R10: While instr_valid_i is low, pc_o, cc_o and the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | An instruction is present this cycle |
| instr_i | input | 80 | Instruction bytes, byte 0 in bits 7:0 |
| peek_sel_i | input | 4 | Register ID to observe |
| pc_o | output | 64 | Program counter |
| status_o | output | 2 | 0 running, 1 illegal instruction |
| cc_o | output | 3 | {ZF, SF, OF} |
| peek_data_o | output | 64 | Value of register peek_sel_i |

## Verification
An instruction presented with instr_valid_i high is taken at the next rising edge. The register write, pc_o, cc_o and status_o all change at that same edge. peek_data_o is combinational from the register file, so the written value is visible as soon as the edge has passed. The bench drives each instruction on a falling edge and withdraws it one falling edge later. It then samples every output on that falling edge, which is exactly one rising edge after the stimulus. Because each step depends on register values left by the steps before it, the bench carries its expected values forward from step to step.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

    localparam logic [3:0] OPC_REG  = 4'h6;
    localparam logic [3:0] OPC_IMM  = 4'hC;
    localparam logic [3:0] REG_NONE = 4'hF;
    localparam int         LEN_REG  = 2;
    localparam int         LEN_IMM  = 10;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ILLEGAL = 2'd1
    } run_state_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } ccode_t;

    typedef struct packed {
        logic       legal;
        logic       is_imm;
        alu_fn_e    fn;
        logic [3:0] src_a;
        logic [3:0] src_b;
        logic [3:0] dst;
        logic [3:0] len;
    } decoded_t;

endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
    import imm_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int IBYTES = 10
) (
    input  logic [8*IBYTES-1:0] instr_i,
    output decoded_t            dec_o,
    output logic [XLEN-1:0]     imm_o
);

    localparam int IMM_LSB = 16;

    logic [3:0] opc, fn_raw, hi_id, lo_id;
    logic       fn_ok, is_reg, is_imm;

    assign opc    = instr_i[7:4];
    assign fn_raw = instr_i[3:0];
    assign hi_id  = instr_i[15:12];
    assign lo_id  = instr_i[11:8];
    assign fn_ok  = (fn_raw[3:2] == 2'b00);
    assign is_reg = (opc == OPC_REG);
    assign is_imm = (opc == OPC_IMM);

    // the constant occupies the bytes after the register byte; byte order is little-endian
    genvar b;
    generate
        for (b = 0; b < XLEN / 8; b++) begin : g_imm_byte
            assign imm_o[8*b +: 8] = instr_i[IMM_LSB + 8*b +: 8];
        end
    endgenerate

    always_comb begin
        dec_o        = '0;
        dec_o.fn     = alu_fn_e'(fn_raw[1:0]);
        dec_o.is_imm = is_imm;
        dec_o.src_a  = hi_id;
        dec_o.src_b  = lo_id;
        if (is_imm) begin
            dec_o.legal = fn_ok && (lo_id == REG_NONE);
            dec_o.dst   = hi_id;
            dec_o.len   = 4'(LEN_IMM);
        end else if (is_reg) begin
            dec_o.legal = fn_ok;
            dec_o.dst   = lo_id;
            dec_o.len   = 4'(LEN_REG);
        end else begin
            dec_o.legal = 1'b0;
            dec_o.dst   = REG_NONE;
            dec_o.len   = 4'd0;
        end
    end

endmodule

// File: rtl/imm_alu_regfile.sv
module imm_alu_regfile #(
    parameter int XLEN  = 64,
    parameter int NREGS = 15,
    parameter int ID_W  = 4,
    parameter int NRD   = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NRD*ID_W-1:0]  rd_id_i,
    output logic [NRD*XLEN-1:0]  rd_data_o,
    input  logic                 we_i,
    input  logic [ID_W-1:0]      wid_i,
    input  logic [XLEN-1:0]      wdata_i
);

    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    genvar p;
    generate
        for (p = 0; p < NRD; p++) begin : g_rd
            logic [ID_W-1:0] id;
            assign id = rd_id_i[p*ID_W +: ID_W];
            always_comb begin
                if (int'(id) < NREGS) rd_data_o[p*XLEN +: XLEN] = regs_q[id];
                else                  rd_data_o[p*XLEN +: XLEN] = '0;
            end
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (we_i && (int'(wid_i) < NREGS)) regs_d[wid_i] = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
    import imm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_fn_e         fn_i,
    input  logic [XLEN-1:0] x_i,
    input  logic [XLEN-1:0] y_i,
    output logic [XLEN-1:0] res_o,
    output ccode_t          cc_o
);

    localparam int MSB = XLEN - 1;

    always_comb begin
        res_o   = '0;
        cc_o.of = 1'b0;
        unique case (fn_i)
            FN_ADD: begin
                res_o   = x_i + y_i;
                cc_o.of = (x_i[MSB] == y_i[MSB]) && (res_o[MSB] != x_i[MSB]);
            end
            FN_SUB: begin
                res_o   = x_i - y_i;
                cc_o.of = (x_i[MSB] != y_i[MSB]) && (res_o[MSB] != x_i[MSB]);
            end
            FN_AND: res_o = x_i & y_i;
            FN_XOR: res_o = x_i ^ y_i;
            default: res_o = '0;
        endcase
        cc_o.zf = (res_o == '0);
        cc_o.sf = res_o[MSB];
    end

endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
    import imm_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PC_W   = 64,
    parameter int IBYTES = 10,
    parameter int NREGS  = 15
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                instr_valid_i,
    input  logic [8*IBYTES-1:0] instr_i,
    input  logic [3:0]          peek_sel_i,
    output logic [PC_W-1:0]     pc_o,
    output logic [1:0]          status_o,
    output logic [2:0]          cc_o,
    output logic [XLEN-1:0]     peek_data_o
);

    localparam int ID_W = 4;
    localparam int NRD  = 3;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        ccode_t          cc;
        run_state_e      st;
    } core_state_t;

    core_state_t state_d, state_q;

    decoded_t        dec;
    logic [XLEN-1:0] imm, val_a, val_b, alu_x, alu_res;
    ccode_t          alu_cc;
    logic [NRD*XLEN-1:0] rd_bus;
    logic            wr_en;

    imm_alu_decode #(.XLEN(XLEN), .IBYTES(IBYTES)) u_dec (
        .instr_i (instr_i),
        .dec_o   (dec),
        .imm_o   (imm)
    );

    imm_alu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .ID_W(ID_W), .NRD(NRD)) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_id_i   ({peek_sel_i, dec.src_b, dec.src_a}),
        .rd_data_o (rd_bus),
        .we_i      (wr_en),
        .wid_i     (dec.dst),
        .wdata_i   (alu_res)
    );

    assign val_a       = rd_bus[0 +: XLEN];
    assign val_b       = rd_bus[XLEN +: XLEN];
    assign peek_data_o = rd_bus[2*XLEN +: XLEN];

    // immediate form: constant is the first operand; register form: rB is
    assign alu_x = dec.is_imm ? imm : val_b;

    imm_alu_exec #(.XLEN(XLEN)) u_exec (
        .fn_i  (dec.fn),
        .x_i   (alu_x),
        .y_i   (val_a),
        .res_o (alu_res),
        .cc_o  (alu_cc)
    );

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        if (instr_valid_i && (state_q.st == ST_RUN)) begin
            if (dec.legal) begin
                wr_en      = 1'b1;
                state_d.cc = alu_cc;
                state_d.pc = state_q.pc + PC_W'(dec.len);
            end else begin
                state_d.st = ST_ILLEGAL;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.pc <= '0;
            state_q.cc <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
            state_q.st <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o     = state_q.pc;
    assign status_o = state_q.st;
    assign cc_o     = state_q.cc;

endmodule

// File: rtl/imm_alu_checker.sv
module imm_alu_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        instr_valid_i,
    input logic [79:0] instr_i,
    input logic [3:0]  peek_sel_i,
    input logic [63:0] pc_o,
    input logic [1:0]  status_o,
    input logic [2:0]  cc_o,
    input logic [63:0] peek_data_o
);

    logic live, fn_ok, imm_ok, reg_ok;
    assign live   = instr_valid_i && (status_o == 2'd0);
    assign fn_ok  = (instr_i[3:2] == 2'b00);
    assign imm_ok = (instr_i[7:4] == 4'hC) && fn_ok && (instr_i[11:8] == 4'hF);
    assign reg_ok = (instr_i[7:4] == 4'h6) && fn_ok;

    // R5
    imm_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && imm_ok) |=> (pc_o == $past(pc_o) + 64'd10));

    // R4
    reg_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && reg_ok) |=> (pc_o == $past(pc_o) + 64'd2));

    // R8
    illegal_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && !imm_ok && !reg_ok) |=> (status_o == 2'd1) && $stable(pc_o) && $stable(cc_o));

    // R9
    illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == 2'd1) |=> (status_o == 2'd1) && $stable(pc_o) && $stable(cc_o));

    // R7
    zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (peek_sel_i == 4'hF) |-> (peek_data_o == 64'd0));

    // R6
    logic_no_of_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && (imm_ok || reg_ok) && instr_i[1]) |=> !cc_o[0]);

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |=> $stable(pc_o) && $stable(cc_o) && $stable(status_o));

endmodule

bind imm_alu_core imm_alu_checker u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .peek_sel_i    (peek_sel_i),
    .pc_o          (pc_o),
    .status_o      (status_o),
    .cc_o          (cc_o),
    .peek_data_o   (peek_data_o)
);

// File: tb/imm_alu_core_tb.sv
`timescale 1ns/1ps
module imm_alu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [79:0] instr = '0;
    logic [3:0]  peek = '0;
    logic [63:0] pc, pdata;
    logic [1:0]  status;
    logic [2:0]  cc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    imm_alu_core dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .instr_valid_i (valid),
        .instr_i       (instr),
        .peek_sel_i    (peek),
        .pc_o          (pc),
        .status_o      (status),
        .cc_o          (cc),
        .peek_data_o   (pdata)
    );

    typedef struct packed {
        logic [79:0] ins;
        logic [3:0]  rid;
        logic [63:0] val;
        logic [2:0]  ccx;
        logic [63:0] pcx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{{64'd10, 8'h0F, 8'hC0}, 4'd0, 64'd10, 3'b000, 64'd10},
        '{{64'd0, 8'h0F, 8'hC1}, 4'd0, 64'hFFFFFFFFFFFFFFF6, 3'b010, 64'd20},
        '{{64'd8, 8'h7F, 8'hC0}, 4'd7, 64'd8, 3'b000, 64'd30},
        '{{64'd0, 8'h07, 8'h60}, 4'd7, 64'hFFFFFFFFFFFFFFFE, 3'b010, 64'd32},
        '{{64'hF0, 8'h7F, 8'hC2}, 4'd7, 64'hF0, 3'b000, 64'd42},
        '{{64'hF0, 8'h7F, 8'hC3}, 4'd7, 64'd0, 3'b100, 64'd52},
        '{{64'h7FFFFFFFFFFFFFFF, 8'h1F, 8'hC0}, 4'd1, 64'h7FFFFFFFFFFFFFFF, 3'b000, 64'd62},
        '{{64'd1, 8'h1F, 8'hC0}, 4'd1, 64'h8000000000000000, 3'b011, 64'd72},
        '{{64'd0, 8'h1F, 8'hC1}, 4'd1, 64'h8000000000000000, 3'b011, 64'd82},
        '{{64'd0, 8'h21, 8'h61}, 4'd1, 64'h8000000000000000, 3'b010, 64'd84},
        '{{64'd5, 8'hFF, 8'hC0}, 4'd15, 64'd0, 3'b000, 64'd94},
        '{{64'h0102030405060708, 8'h3F, 8'hC0}, 4'd3, 64'h0102030405060708, 3'b000, 64'd104}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [79:0] ins);
        @(negedge clk);
        instr = ins;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic peek_reg(input logic [3:0] id, output logic [63:0] v);
        peek = id;
        #1;
        v = pdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        do_reset();
        // R1 reset state
        chk("R1", "pc", pc, 64'd0);
        chk("R1", "status", 64'(status), 64'd0);
        chk("R1", "cc", 64'(cc), 64'd4);
        for (int r = 0; r < 16; r++) begin
            peek_reg(4'(r), v);
            chk("R1", "reg", v, 64'd0);
        end

        // R2 R3 R4 R5 R6 R7: vector walk, each entry one instruction
        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].ins);
            peek_reg(VECS[k].rid, v);
            chk("R2/R3/R4/R7", "result", v, VECS[k].val);
            chk("R6", "cc", 64'(cc), 64'(VECS[k].ccx));
            chk("R5/R4", "pc", pc, VECS[k].pcx);
        end
        // R7 write to register 15 left others untouched
        peek_reg(4'd15, v);
        chk("R7", "r15", v, 64'd0);

        // R10 idle cycles with a legal pattern on the bus
        @(negedge clk);
        instr = {64'd99, 8'h3F, 8'hC0};
        @(negedge clk);
        @(negedge clk);
        chk("R10", "pc", pc, 64'd104);
        peek_reg(4'd3, v);
        chk("R10", "r3", v, 64'h0102030405060708);

        // R8 function code above 3
        issue({64'd1, 8'h3F, 8'hC4});
        chk("R8", "status", 64'(status), 64'd1);
        chk("R8", "pc", pc, 64'd104);
        chk("R8", "cc", 64'(cc), 64'd0);
        peek_reg(4'd3, v);
        chk("R8", "r3", v, 64'h0102030405060708);

        // R9 legal instruction ignored after stop
        issue({64'd1, 8'h3F, 8'hC0});
        chk("R9", "status", 64'(status), 64'd1);
        chk("R9", "pc", pc, 64'd104);
        peek_reg(4'd3, v);
        chk("R9", "r3", v, 64'h0102030405060708);

        // R1 reset clears the stop
        do_reset();
        chk("R1", "status after reset", 64'(status), 64'd0);
        chk("R1", "pc after reset", pc, 64'd0);

        // R8 unknown opcode
        issue({64'd1, 8'h3F, 8'h50});
        chk("R8", "opcode5 status", 64'(status), 64'd1);
        chk("R8", "opcode5 pc", pc, 64'd0);

        // R8 immediate with a second register named
        do_reset();
        issue({64'd3, 8'h30, 8'hC0});
        chk("R8", "nibble status", 64'(status), 64'd1);
        peek_reg(4'd3, v);
        chk("R8", "nibble r3", v, 64'd0);
        peek_reg(4'd0, v);
        chk("R8", "nibble r0", v, 64'd0);

        // R8 register form with fn 4
        do_reset();
        issue({64'd0, 8'h12, 8'h64});
        chk("R8", "rr fn4 status", 64'(status), 64'd1);
        chk("R8", "rr fn4 cc", 64'(cc), 64'd4);

        finish_run();
    end

endmodule